// File: doc/BRIEF.md
# Integer ALU with Serial Shifter

This block is the arithmetic and logic unit of a small 32-bit integer core. It receives two operands that were already chosen upstream (either could be a register, the program counter or an immediate; the unit treats them all the same), a 3-bit operation code taken from the instruction's funct3 field, a qualifier bit and an operation-enable bit. Addition, subtraction, the two set-less-than compares and the three bitwise operations settle combinationally within one cycle.

When the operation-enable bit is low, the operation code and qualifier are forced to zero. The unit then adds its operands. Address, jump-target and upper-immediate computations use this path to share the one adder.

Shifts move the operand one bit position per clock to save area. The core starts a shift with a single-cycle `start` strobe. It then holds off while `busy` is high and takes the result once `busy` has fallen. The result stays in a register until the next accepted start.

Top module: `rv_int_alu`

## Requirements
- R1: With `op_en` low, `result` equals `opa + opb` modulo 2^32, whatever `op_code` and `qual` hold.
- R2: With `op_en` high and `op_code` 000, `result` is `opa + opb` when `qual` is 0 and `opa - opb` when `qual` is 1, both modulo 2^32.
- R3: Code 010 gives 1 when `opa` is less than `opb` as signed numbers, and 0 otherwise. Code 011 makes the same comparison unsigned. The upper 31 bits of `result` are zero for both codes.
- R4: Code 100 gives XOR, 110 gives OR and 111 gives AND. `qual` has no effect on these codes.
- R5: Code 001 is a left shift and code 101 is a right shift. The shift amount is `opb[4:0]` and the upper bits of `opb` are ignored. On code 101, `qual` 1 selects arithmetic shifting (bit 31 copied into the vacated bits on every step) and `qual` 0 selects logical shifting. On code 001, `qual` is ignored. Logical and left shifts fill with zeros.
- R6: A shift with amount n > 0 is accepted on a clock edge where `start` is high and `busy` is low. `busy` is high for exactly the n cycles that follow that edge. After it falls, `result` holds the shifted value.
- R7: A shift with amount 0 never raises `busy`. After the start edge, `result` equals `opa`.
- R8: `start` while `busy` is high is ignored. New operand values presented with it do not change the shift in progress or its final result.
- R9: Reset (active low, asynchronous) clears `busy` and the shift result register. A shift code then reads 0 on `result`.
- R10: After a shift completes, its result stays on `result` (for a shift code) until the next accepted start, even when the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that launches a shift when the effective code is a shift |
| op_en | input | 1 | 1: use `op_code`/`qual`; 0: force ADD |
| op_code | input | 3 | Operation code (funct3) |
| qual | input | 1 | Qualifier: subtract on 000, arithmetic on 101 |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; bits 4:0 are the shift amount |
| result | output | 32 | Operation result |
| busy | output | 1 | Shift in progress; caller must wait |

## Verification
The embedded assertions assume that the caller keeps `op_en`, `op_code` and `qual` steady from the start edge until `busy` drops, so that a shift code stays selected and `result` keeps showing the shift register. They also treat a start pulsed during `busy` as legal input that must be discarded. The bench changes the control inputs only at falling edges, and between shifts only while `busy` is low. It deliberately pulses `start` with altered operands in the middle of shifts to test R8. The combinational sweeps keep `start` low, so the shifter never runs underneath them.

// File: rtl/rv_alu_pkg.sv
`timescale 1ns/1ps
package rv_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SRX  = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } alu_op_e;

  function automatic logic op_is_shift(alu_op_e op);
    return (op == OP_SLL) || (op == OP_SRX);
  endfunction

endpackage

// File: rtl/rv_alu_opsel.sv
`timescale 1ns/1ps
module rv_alu_opsel
  import rv_alu_pkg::*;
(
  input  logic       op_en,
  input  logic [2:0] op_code,
  input  logic       qual,
  output alu_op_e    eff_op,
  output logic       eff_qual,
  output logic       eff_shift,
  output logic       shift_left,
  output logic       shift_arith
);

  always_comb begin
    if (op_en) begin
      eff_op   = alu_op_e'(op_code);
      eff_qual = qual;
    end else begin
      eff_op   = OP_ADD;
      eff_qual = 1'b0;
    end
    eff_shift   = op_is_shift(eff_op);
    shift_left  = (eff_op == OP_SLL);
    shift_arith = (eff_op == OP_SRX) && eff_qual;
  end

endmodule

// File: rtl/rv_alu_comb.sv
`timescale 1ns/1ps
module rv_alu_comb
  import rv_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         qual,
  output logic [W-1:0] y
);

  logic         sub_en;
  logic [W:0]   sum_x;
  logic         lt_signed;
  logic         lt_unsigned;

  always_comb begin
    sub_en      = ((op == OP_ADD) && qual) || (op == OP_SLT) || (op == OP_SLTU);
    sum_x       = {1'b0, a} + {1'b0, (b ^ {W{sub_en}})} + {{W{1'b0}}, sub_en};
    lt_unsigned = ~sum_x[W];
    lt_signed   = (a[W-1] ^ b[W-1]) ? a[W-1] : sum_x[W-1];
  end

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum_x[W-1:0];
      OP_SLT:  y = {{(W-1){1'b0}}, lt_signed};
      OP_SLTU: y = {{(W-1){1'b0}}, lt_unsigned};
      OP_XOR:  y = a ^ b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = {W{1'b0}};
    endcase
  end

endmodule

// File: rtl/rv_alu_serial_shift.sv
`timescale 1ns/1ps
module rv_alu_serial_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_shift,
  input  logic          dir_left,
  input  logic          arith,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  q,
  output logic          busy
);

  logic [W-1:0]  sh_q,   sh_d;
  logic [SW-1:0] cnt_q,  cnt_d;
  logic          busy_q, busy_d;
  logic          left_q, left_d;
  logic          ar_q,   ar_d;
  logic          accept;
  logic          upd_en;

  assign accept = start && is_shift && !busy_q;
  assign upd_en = busy_q || accept;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    left_d = left_q;
    ar_d   = ar_q;
    if (busy_q) begin
      if (left_q) sh_d = {sh_q[W-2:0], 1'b0};
      else        sh_d = {ar_q & sh_q[W-1], sh_q[W-1:1]};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == SW'(1)) busy_d = 1'b0;
    end else if (accept) begin
      sh_d   = din;
      cnt_d  = amt;
      busy_d = (amt != '0);
      left_d = dir_left;
      ar_d   = arith;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      left_q <= 1'b0;
      ar_q   <= 1'b0;
    end else if (upd_en) begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      left_q <= left_d;
      ar_q   <= ar_d;
    end
  end

  assign q    = sh_q;
  assign busy = busy_q;

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_shift && !busy && amt != '0) |=> busy);
  assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
  assert_zero_amt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_shift && !busy && amt == '0) |=> (!busy && q == $past(din)));
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - 1'b1) && $stable(left_q) && $stable(ar_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && is_shift)) |=> $stable(q));

endmodule

// File: rtl/rv_int_alu.sv
`timescale 1ns/1ps
module rv_int_alu
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_en,
  input  logic [2:0]      op_code,
  input  logic            qual,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            busy
);

  alu_op_e         eff_op;
  logic            eff_qual;
  logic            eff_shift;
  logic            shift_left;
  logic            shift_arith;
  logic [XLEN-1:0] comb_y;
  logic [XLEN-1:0] shift_y;

  rv_alu_opsel u_opsel (
    .op_en       (op_en),
    .op_code     (op_code),
    .qual        (qual),
    .eff_op      (eff_op),
    .eff_qual    (eff_qual),
    .eff_shift   (eff_shift),
    .shift_left  (shift_left),
    .shift_arith (shift_arith)
  );

  rv_alu_comb #(.W(XLEN)) u_comb (
    .a    (opa),
    .b    (opb),
    .op   (eff_op),
    .qual (eff_qual),
    .y    (comb_y)
  );

  rv_alu_serial_shift #(.W(XLEN), .SW(SHW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_shift (eff_shift),
    .dir_left (shift_left),
    .arith    (shift_arith),
    .din      (opa),
    .amt      (opb[SHW-1:0]),
    .q        (shift_y),
    .busy     (busy)
  );

  assign result = eff_shift ? shift_y : comb_y;

  assert_force_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |-> (result == opa + opb));
  assert_slt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_code == 3'b010 || op_code == 3'b011)) |-> (result[XLEN-1:1] == '0));

endmodule

// File: tb/rv_int_alu_tb_top.sv
`timescale 1ns/1ps
module rv_int_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        op_en;
  logic [2:0]  op_code;
  logic        qual;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [31:0] result;
  logic        busy;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  rv_int_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_en(op_en),
    .op_code(op_code), .qual(qual), .opa(opa), .opb(opb),
    .result(result), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hDEAD_BEEF;
      default: return 32'h0000_0005;
    endcase
  endfunction

  function automatic logic [31:0] ref_comb(input logic en, input logic [2:0] op,
                                           input logic q, input logic [31:0] a,
                                           input logic [31:0] b);
    if (!en) return a + b;
    case (op)
      3'b000: return q ? a - b : a + b;
      3'b010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'b011: return (a < b) ? 32'd1 : 32'd0;
      3'b100: return a ^ b;
      3'b110: return a | b;
      3'b111: return a & b;
      default: return 32'hxxxx_xxxx;
    endcase
  endfunction

  function automatic logic [31:0] ref_shift(input logic left, input logic ar,
                                            input logic [31:0] a, input int n);
    logic [31:0] v = a;
    for (int s = 0; s < n; s++) begin
      if (left) v = {v[30:0], 1'b0};
      else      v = {ar & v[31], v[31:1]};
    end
    return v;
  endfunction

  task automatic run_shift(input logic [2:0] op, input logic q, input logic [31:0] a,
                           input int n, input logic poke);
    int k;
    logic [31:0] exp;
    exp = ref_shift(op == 3'b001, (op == 3'b101) && q, a, n);
    @(negedge clk);
    op_en = 1'b1; op_code = op; qual = q; opa = a;
    opb = {27'h5A5A5A5 ^ 27'(n), 5'(n)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (busy && k < 64) begin
      if (poke && k == 1) begin
        opa = ~a; opb = 32'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    opa = a; opb = {27'h5A5A5A5 ^ 27'(n), 5'(n)};
    #1;
    if (n == 0) chk("R7 no busy on zero shift", 32'(k), 32'd0);
    else        chk("R6 busy length", 32'(k), 32'(n));
    if (poke)           chk("R8 start during busy ignored", result, exp);
    else if (op == 3'b001) chk("R5 left shift", result, exp);
    else if (q)         chk("R5 arithmetic right shift", result, exp);
    else                chk("R5 logical right shift", result, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_en = 1'b1; op_code = 3'b001; qual = 1'b0;
    opa = 32'hCAFE_F00D; opb = 32'd4;
    repeat (3) @(negedge clk);
    chk("R9 busy low in reset", {31'd0, busy}, 32'd0);
    chk("R9 shift register cleared", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 result zero after reset", result, 32'd0);

    // R1 R2 R3 R4: combinational sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int o = 0; o < 8; o++)
          for (int qq = 0; qq < 2; qq++)
            for (int e = 0; e < 2; e++) begin
              if (e == 1 && (o == 1 || o == 5)) continue;
              @(negedge clk);
              op_en = e[0]; op_code = o[2:0]; qual = qq[0];
              opa = pat(i); opb = pat(j);
              #1;
              if (e == 0)                  chk("R1 forced add", result, ref_comb(1'b0, 3'(o), qq[0], pat(i), pat(j)));
              else if (o == 0)             chk("R2 add/sub", result, ref_comb(1'b1, 3'(o), qq[0], pat(i), pat(j)));
              else if (o == 2 || o == 3)   chk("R3 set-less-than", result, ref_comb(1'b1, 3'(o), qq[0], pat(i), pat(j)));
              else                         chk("R4 logic op", result, ref_comb(1'b1, 3'(o), qq[0], pat(i), pat(j)));
            end

    // R5 R6 R7: every amount, every shift kind
    for (int n = 0; n < 32; n++)
      for (int kind = 0; kind < 4; kind++)
        for (int p = 2; p < 7; p += 2)
          run_shift(kind[1] ? 3'b101 : 3'b001, kind[0], pat(p + (n % 2)), n, 1'b0);

    // R8: start pulses during busy with altered operands
    run_shift(3'b101, 1'b1, 32'h8123_4567, 9, 1'b1);
    run_shift(3'b001, 1'b0, 32'h0F0F_0F0F, 31, 1'b1);
    run_shift(3'b101, 1'b0, 32'hF000_0001, 2, 1'b1);

    // R10: hold with changing operands and no start
    run_shift(3'b001, 1'b0, 32'h0000_00A5, 7, 1'b0);
    @(negedge clk);
    opa = 32'h1111_1111; opb = 32'h0000_0013;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 result held", result, 32'h0000_5280);
    chk("R10 busy stays low", {31'd0, busy}, 32'd0);

    // R9: reset in the middle of a shift
    @(negedge clk);
    op_code = 3'b101; qual = 1'b1; opa = 32'h8000_0000; opb = 32'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 busy cleared mid-shift", {31'd0, busy}, 32'd0);
    chk("R9 result cleared mid-shift", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 stays idle after reset", {31'd0, busy}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule